// File: doc/BRIEF.md
# Page Write Buffer and Commit Controller

This block sits between a two-wire serial memory bus engine and a byte-wide memory array. When the bus engine opens a write session it passes in a start address. The upper address bits pick a page of `PAGE_BYTES` bytes, and that page stays fixed for the whole session. The lower bits give the first byte offset. Each data byte that follows is stored at the current in-page offset, and a per-byte valid mask records which offsets now hold data. The offset counts up and wraps back to zero at the end of the page, so a long burst overwrites the bytes it loaded earlier.

A commit indication, which the bus engine raises on a STOP, starts one write cycle. Busy goes high for exactly `WR_CYCLES` system clocks. During the first `PAGE_BYTES` of those clocks a sequencer walks the page in ascending offset order. It issues one array write for each valid offset and leaves the other offsets of the page untouched. An abort, or a commit with no bytes loaded, throws the session away and starts no cycle. While busy is high, every request is ignored.

The control is a four-state machine:
- IDLE waits for a session start.
- LOAD collects bytes.
- FLUSH scans the page and writes.
- HOLD waits for the write timer to run out.

Its transitions are:
- start: IDLE to LOAD.
- restart: LOAD to LOAD, when a fresh start arrives.
- abort: LOAD to IDLE.
- empty: LOAD to IDLE, on a commit with no bytes.
- commit: LOAD to FLUSH.
- scan-done: FLUSH to HOLD, after the last offset.
- expire: HOLD to IDLE, on the final timer count.

Top module: `pgbuf_commit`

## Requirements
- R1: After reset, `busy` and `mem_we` are low.
- R2: On `sess_start` (with `busy` low), bits [ADDR_W-1:5] of `sess_addr` are latched as the page. Every array write of that session uses this page in `mem_addr[ADDR_W-1:5]`. The in-page offset is placed in `mem_addr[4:0]`, with PAGE_BYTES=32.
- R3: The first data byte goes to offset `sess_addr[4:0]`. Each following byte goes to the next offset, and offset 31 is followed by offset 0 of the same page.
- R4: A byte loaded at an offset that already holds data replaces it. Each offset is written to the array at most once per commit, with the last byte loaded there.
- R5: A commit writes only the offsets that hold data. Writes go out in ascending offset order, one `mem_we` pulse per byte, and no write occurs outside a commit.
- R6: `busy` rises on the clock edge that accepts a commit and stays high for exactly `WR_CYCLES` cycles. Every array write of that commit falls inside this window.
- R7: An `abort` in a session, or a commit with no data bytes, produces no array write and no `busy`. The discarded bytes are not written by any later commit.
- R8: While `busy` is high, `sess_start`, `data_vld`, `commit` and `abort` are ignored. No session is open after the window, so a later lone `commit` does nothing.
- R9: A data byte presented in the same cycle as `commit` is included in the commit. A data byte presented in the same cycle as `abort` is dropped.
- R10: After a commit the valid mask is empty. The next session writes only the offsets it loads itself.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sess_start | input | 1 | Pulse: open a write session at `sess_addr` |
| sess_addr | input | ADDR_W | Start address (page and byte offset) |
| data_vld | input | 1 | Pulse: `data_byte` is a new write byte |
| data_byte | input | 8 | Write data byte |
| commit | input | 1 | Pulse: session ended by STOP, start write cycle |
| abort | input | 1 | Pulse: discard session (protect or error) |
| busy | output | 1 | Internal write cycle in progress |
| mem_we | output | 1 | Array write strobe |
| mem_addr | output | ADDR_W | Array write address |
| mem_wdata | output | 8 | Array write data |

## Verification
Two pairs of functions can land in the same cycle. The first pair is the loading of the final byte together with the commit that ends the session. The second pair is a byte together with an abort. The bench drives `data_vld` and `commit` in one cycle and expects the byte to appear among the scoreboard writes. It then drives `data_vld` and `abort` together and expects no write and no busy window. It also issues start, data and commit requests inside a running busy window. These must leave the window length unchanged and must not open a session.

// File: rtl/pgbuf_pkg.sv
package pgbuf_pkg;
    typedef enum logic [1:0] {
        S_IDLE  = 2'd0,
        S_LOAD  = 2'd1,
        S_FLUSH = 2'd2,
        S_HOLD  = 2'd3
    } pg_state_t;
endpackage

// File: rtl/pgbuf_store.sv
module pgbuf_store #(
    parameter int PAGE_BYTES = 32,
    localparam int OFF_W = $clog2(PAGE_BYTES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             ld,
    input  logic [OFF_W-1:0] ld_off,
    input  logic             wr_en,
    input  logic [7:0]       wr_data,
    input  logic             busy,
    input  logic [OFF_W-1:0] rd_idx,
    output logic [7:0]       rd_data,
    output logic             rd_vld,
    output logic             any_vld
);
    localparam logic [OFF_W-1:0] LAST_OFF = OFF_W'(PAGE_BYTES - 1);

    logic [7:0]            bytes_q [PAGE_BYTES];
    logic [PAGE_BYTES-1:0] mask_q;
    logic [OFF_W-1:0]      ptr_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask_q <= '0;
            ptr_q  <= '0;
        end else begin
            if (clr)
                mask_q <= '0;
            else if (wr_en)
                mask_q[ptr_q] <= 1'b1;
            if (ld)
                ptr_q <= ld_off;
            else if (wr_en)
                ptr_q <= (ptr_q == LAST_OFF) ? '0 : ptr_q + 1'b1;
        end
    end

    for (genvar g = 0; g < PAGE_BYTES; g++) begin : g_byte
        always_ff @(posedge clk) begin
            if (wr_en && !ld && ptr_q == OFF_W'(g))
                bytes_q[g] <= wr_data;
        end
    end

    assign rd_data = bytes_q[rd_idx];
    assign rd_vld  = mask_q[rd_idx];
    assign any_vld = |mask_q;

    // R8: the sequencer never loads bytes during a write window
    p_no_load_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> !busy);
endmodule

// File: rtl/pgbuf_timer.sv
module pgbuf_timer #(
    parameter int WR_CYCLES = 250000,
    localparam int CNT_W = $clog2(WR_CYCLES)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic run,
    output logic last
);
    localparam logic [CNT_W-1:0] LOAD_VAL = CNT_W'(WR_CYCLES - 1);

    logic [CNT_W-1:0] cnt_q;
    logic             run_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_q <= 1'b0;
            cnt_q <= '0;
        end else if (start) begin
            run_q <= 1'b1;
            cnt_q <= LOAD_VAL;
        end else if (run_q) begin
            if (cnt_q == '0)
                run_q <= 1'b0;
            else
                cnt_q <= cnt_q - 1'b1;
        end
    end

    assign run  = run_q;
    assign last = run_q && (cnt_q == '0);

    // R8: a new cycle is never launched on top of a running one
    p_start_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> !run_q);
    // R6: the final count always ends the window
    p_last_ends_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (last && !start) |=> !run_q);
endmodule

// File: rtl/pgbuf_seq.sv
module pgbuf_seq
    import pgbuf_pkg::*;
#(
    parameter int ADDR_W = 13,
    parameter int PAGE_BYTES = 32,
    localparam int OFF_W = $clog2(PAGE_BYTES),
    localparam int PAGE_W = ADDR_W - OFF_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sess_start,
    input  logic [ADDR_W-1:0] sess_addr,
    input  logic              data_vld,
    input  logic              commit,
    input  logic              abort,
    input  logic              any_vld,
    input  logic              rd_vld,
    input  logic [7:0]        rd_data,
    input  logic              busy,
    input  logic              tmr_last,
    output logic              st_clr,
    output logic              st_ld,
    output logic              st_wr,
    output logic [OFF_W-1:0]  rd_idx,
    output logic              tmr_start,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [7:0]        mem_wdata
);
    localparam logic [OFF_W-1:0] LAST_OFF = OFF_W'(PAGE_BYTES - 1);

    pg_state_t        state_q, state_d;
    logic [PAGE_W-1:0] page_q;
    logic [OFF_W-1:0]  idx_q;

    // next state and control strobes
    always_comb begin
        state_d   = state_q;
        st_clr    = 1'b0;
        st_ld     = 1'b0;
        st_wr     = 1'b0;
        tmr_start = 1'b0;
        unique case (state_q)
            S_IDLE: begin
                if (sess_start) begin
                    state_d = S_LOAD;
                    st_clr  = 1'b1;
                    st_ld   = 1'b1;
                end
            end
            S_LOAD: begin
                if (abort) begin
                    state_d = S_IDLE;
                    st_clr  = 1'b1;
                end else if (sess_start) begin
                    st_clr = 1'b1;
                    st_ld  = 1'b1;
                end else if (commit) begin
                    if (any_vld || data_vld) begin
                        state_d   = S_FLUSH;
                        st_wr     = data_vld;
                        tmr_start = 1'b1;
                    end else begin
                        state_d = S_IDLE;
                        st_clr  = 1'b1;
                    end
                end else if (data_vld) begin
                    st_wr = 1'b1;
                end
            end
            S_FLUSH: begin
                if (idx_q == LAST_OFF) begin
                    state_d = S_HOLD;
                    st_clr  = 1'b1;
                end
            end
            S_HOLD: begin
                if (tmr_last)
                    state_d = S_IDLE;
            end
            default: state_d = S_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= S_IDLE;
        else
            state_q <= state_d;
    end

    assign rd_idx = idx_q;

    // registered outputs, page latch and scan index
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            page_q    <= '0;
            idx_q     <= '0;
            mem_we    <= 1'b0;
            mem_addr  <= '0;
            mem_wdata <= '0;
        end else begin
            mem_we <= 1'b0;
            if (st_ld)
                page_q <= sess_addr[ADDR_W-1:OFF_W];
            if (state_q == S_FLUSH) begin
                mem_we    <= rd_vld;
                mem_addr  <= {page_q, idx_q};
                mem_wdata <= rd_data;
                idx_q     <= (idx_q == LAST_OFF) ? '0 : idx_q + 1'b1;
            end else begin
                idx_q <= '0;
            end
        end
    end

    // R7: an abort in a session never opens a write window
    p_abort_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_LOAD && abort) |=> !busy);
    // R6: the machine leaves HOLD exactly when the timer expires
    p_hold_exit_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_HOLD && tmr_last) |=> (state_q == S_IDLE && !busy));
    // R5: the scan phase only exists inside a busy window
    p_flush_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_FLUSH) |-> busy);
endmodule

// File: rtl/pgbuf_commit.sv
module pgbuf_commit #(
    parameter int ADDR_W = 13,
    parameter int PAGE_BYTES = 32,
    parameter int WR_CYCLES = 250000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sess_start,
    input  logic [ADDR_W-1:0] sess_addr,
    input  logic              data_vld,
    input  logic [7:0]        data_byte,
    input  logic              commit,
    input  logic              abort,
    output logic              busy,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [7:0]        mem_wdata
);
    localparam int OFF_W = $clog2(PAGE_BYTES);

    logic             st_clr, st_ld, st_wr, any_vld, rd_vld;
    logic [7:0]       rd_data;
    logic [OFF_W-1:0] rd_idx;
    logic             tmr_start, tmr_run, tmr_last;

    assign busy = tmr_run;

    pgbuf_seq #(.ADDR_W(ADDR_W), .PAGE_BYTES(PAGE_BYTES)) u_seq (
        .clk(clk), .rst_n(rst_n),
        .sess_start(sess_start), .sess_addr(sess_addr),
        .data_vld(data_vld), .commit(commit), .abort(abort),
        .any_vld(any_vld), .rd_vld(rd_vld), .rd_data(rd_data),
        .busy(tmr_run), .tmr_last(tmr_last),
        .st_clr(st_clr), .st_ld(st_ld), .st_wr(st_wr), .rd_idx(rd_idx),
        .tmr_start(tmr_start),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata)
    );

    pgbuf_store #(.PAGE_BYTES(PAGE_BYTES)) u_store (
        .clk(clk), .rst_n(rst_n),
        .clr(st_clr), .ld(st_ld), .ld_off(sess_addr[OFF_W-1:0]),
        .wr_en(st_wr), .wr_data(data_byte), .busy(tmr_run),
        .rd_idx(rd_idx), .rd_data(rd_data), .rd_vld(rd_vld),
        .any_vld(any_vld)
    );

    pgbuf_timer #(.WR_CYCLES(WR_CYCLES)) u_timer (
        .clk(clk), .rst_n(rst_n), .start(tmr_start),
        .run(tmr_run), .last(tmr_last)
    );

    // R6: every array write falls inside the busy window
    p_we_in_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> busy);
    // R6: busy only rises in response to a commit
    p_rise_on_commit_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(commit));
endmodule

// File: tb/tb_pgbuf_commit.sv
module tb_pgbuf_commit;
    localparam int AW  = 13;
    localparam int PB  = 32;
    localparam int WRC = 64;

    logic          clk = 1'b0, rst_n = 1'b0;
    logic          sess_start = 0, data_vld = 0, commit = 0, abort = 0;
    logic [AW-1:0] sess_addr = '0;
    logic [7:0]    data_byte = '0;
    logic          busy, mem_we;
    logic [AW-1:0] mem_addr;
    logic [7:0]    mem_wdata;

    int checks = 0, errors = 0, windows_exp = 0, windows_seen = 0;
    logic [AW+7:0] sb_q[$];

    always #2 clk = ~clk;

    pgbuf_commit #(.ADDR_W(AW), .PAGE_BYTES(PB), .WR_CYCLES(WRC)) dut (
        .clk(clk), .rst_n(rst_n), .sess_start(sess_start), .sess_addr(sess_addr),
        .data_vld(data_vld), .data_byte(data_byte), .commit(commit), .abort(abort),
        .busy(busy), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata));

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // monitor: pops scoreboard on each write, measures busy windows
    int  bcnt = 0;
    logic bprev = 1'b0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (mem_we) begin
                if (sb_q.size() == 0) begin
                    chk(0, "R5/R7 unexpected write", int'(mem_addr), -1);
                end else begin
                    logic [AW+7:0] e;
                    e = sb_q.pop_front();
                    chk({mem_addr, mem_wdata} == e, "R2/R3/R4/R5 write",
                        int'({mem_addr, mem_wdata}), int'(e));
                end
            end
            if (busy) bcnt++;
            if (bprev && !busy) begin
                windows_seen++;
                chk(bcnt == WRC, "R6 busy length", bcnt, WRC);
                chk(sb_q.size() == 0, "R6 writes outside window", sb_q.size(), 0);
                bcnt = 0;
            end
            bprev = busy;
        end
    end

    // mode 0: commit after bytes, 1: abort after bytes,
    // 2: commit with last byte, 3: abort with last byte
    task automatic session(input logic [AW-1:0] a, input int n, input logic [7:0] base,
                           input int mode);
        logic [7:0] val [PB];
        bit         vld [PB];
        int         off;
        for (int i = 0; i < PB; i++) vld[i] = 0;
        off = int'(a[4:0]);
        for (int i = 0; i < n; i++) begin
            if (!(mode == 3 && i == n - 1)) begin
                val[off] = base + 8'(i);
                vld[off] = 1;
            end
            off = (off + 1) % PB;
        end
        if ((mode == 0 || mode == 2) && n > 0) begin
            windows_exp++;
            for (int o = 0; o < PB; o++)
                if (vld[o]) sb_q.push_back({a[AW-1:5], 5'(o), val[o]});
        end
        @(negedge clk); sess_start = 1; sess_addr = a;
        @(negedge clk); sess_start = 0;
        for (int i = 0; i < n; i++) begin
            data_vld = 1; data_byte = base + 8'(i);
            if (i == n - 1 && mode == 2) commit = 1;
            if (i == n - 1 && mode == 3) abort = 1;
            @(negedge clk);
            data_vld = 0; commit = 0; abort = 0;
        end
        if (mode == 0) begin commit = 1; @(negedge clk); commit = 0; end
        if (mode == 1) begin abort = 1; @(negedge clk); abort = 0; end
    endtask

    task automatic quiet(input string req, input int cyc);
        bit saw = 0;
        for (int i = 0; i < cyc; i++) begin
            @(negedge clk);
            if (busy) saw = 1;
        end
        chk(!saw, req, int'(saw), 0);
    endtask

    task automatic wait_idle();
        @(negedge clk);
        while (busy) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(busy == 0 && mem_we == 0, "R1 reset", {busy, mem_we}, 0);
        rst_n = 1;
        @(negedge clk);
        chk(busy == 0 && mem_we == 0, "R1 after release", {busy, mem_we}, 0);

        session(13'h0105, 1, 8'hA0, 0); wait_idle();        // R2 single byte
        session(13'h1F3E, 5, 8'h10, 0); wait_idle();        // R3 wrap 30..2
        session(13'h0040, 34, 8'h40, 0); wait_idle();       // R4 overwrite
        session(13'h0222, 3, 8'h77, 0); wait_idle();        // R10 fresh mask

        session(13'h0300, 4, 8'h55, 1); quiet("R7 abort busy", 10);
        session(13'h0300, 0, 8'h00, 0); quiet("R7 empty commit busy", 10);
        session(13'h0308, 1, 8'hC3, 0); wait_idle();        // R7 no stale bytes

        session(13'h0400, 3, 8'h90, 2); wait_idle();        // R9 byte+commit
        session(13'h0400, 2, 8'h31, 3); quiet("R9 byte+abort busy", 10);

        // R8: requests inside the window are ignored
        session(13'h0500, 2, 8'hE0, 0);
        repeat (3) @(negedge clk);
        chk(busy == 1, "R8 window open", busy, 1);
        sess_start = 1; sess_addr = 13'h0600; @(negedge clk); sess_start = 0;
        data_vld = 1; data_byte = 8'h12; @(negedge clk); data_vld = 0;
        commit = 1; @(negedge clk); commit = 0;
        abort = 1; @(negedge clk); abort = 0;
        wait_idle();
        commit = 1; @(negedge clk); commit = 0;
        quiet("R8 no session after busy", 10);

        chk(windows_seen == windows_exp, "R6 window count", windows_seen, windows_exp);
        chk(sb_q.size() == 0, "R5 pending writes", sb_q.size(), 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule